// File: doc/BRIEF.md
# Channel Command Stream Decoder

This block sits at the front of a host command processor and parses a stream of 32-bit command words. Each word arrives on a valid/ready stream. The block tags the word as either a header or a payload word. For a header it breaks out the operation fields. For a payload word it reports the register the word is aimed at. It counts the payload words that belong to each header, so that a data word that happens to look like a command is never read as one.

Decoding is combinational from the presented word and a small amount of tracking state. The decoded view of a word is therefore valid in the same cycle the word is offered. The tracking state moves only when the downstream consumer accepts the word. Register writes, gather fetches and lock arbitration are left to the blocks that consume these outputs.

Top module: `cmd_stream_decoder`

## Requirements
- R1: The opcode is bits 31:28 of a header: 0 set-class, 1 incrementing write, 2 non-incrementing write, 3 masked write, 4 immediate, 5 restart, 6 gather, 14 extend. Every offered word is tagged either header (`out_is_hdr`) or payload (`out_is_pld`). A payload word reports the opcode of its header.
- R2: A set-class header reports class = bits 15:6, offset = bits 27:16 and mask = bits 5:0. It is followed by as many payload words as the mask has set bits. A zero mask gives no payload. The new class is shown on the header and on every later word until the next set-class or reset.
- R3: Incrementing and non-incrementing writes report offset = bits 27:16 and count = bits 15:0, and that many payload words follow. A zero count means no payload. Payload offsets go up by one per word for the incrementing write and stay at the header offset for the non-incrementing write.
- R4: A masked write reports offset = bits 27:16 and mask = bits 15:0. One payload word follows for each set mask bit. Payload word k targets header offset plus the index of the k-th set bit, counted from bit 0 upward. Set-class payload uses the same rule.
- R5: An immediate header reports data = bits 15:0 and offset = bits 27:16, and has no payload.
- R6: A restart header reports the target address {bits 27:0, 4'b0000} and has no payload.
- R7: A gather header reports offset = bits 27:16, insert flag = bit 15, type flag = bit 14 and word count = bits 13:0. Exactly one payload word follows, tagged `out_gth_addr` and carrying the header offset.
- R8: An extend header reports index = bits 7:0 and a lock action from sub-opcode bits 27:24: 0 gives acquire (`out_lock_op`=1), 1 gives release (2), any other value gives unknown (3). Non-extend words show 0.
- R9: Opcodes 7 to 13 and 15 raise `out_undef` and have no payload, so the next word is a header.
- R10: While `out_ready` is low, `in_ready` is low and the word is not consumed. The remaining-payload state holds, and the same payload view is shown until the word is accepted.
- R11: A synchronous reset returns the block to expecting a header and clears the current class to 0.
- R12: `out_pld_last` is high only on the final payload word of a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word offered |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Word consumed this cycle when valid |
| out_ready | input | 1 | Consumer accepts the decoded word |
| out_valid | output | 1 | Decoded view valid |
| out_is_hdr | output | 1 | Word is a header |
| out_is_pld | output | 1 | Word is payload |
| out_opcode | output | 4 | Opcode of the header (or of the owning header for payload) |
| out_class | output | 10 | Current class |
| out_offset | output | 12 | Header offset, or target register for payload |
| out_mask | output | 16 | Mask field of set-class or masked write |
| out_count | output | 16 | Count field of writes and gather |
| out_imm | output | 16 | Immediate data |
| out_lock_idx | output | 8 | Extend index |
| out_lock_op | output | 2 | 0 none, 1 acquire, 2 release, 3 unknown |
| out_restart_addr | output | 32 | Restart target address |
| out_gth_insert | output | 1 | Gather insert flag |
| out_gth_type | output | 1 | Gather type flag |
| out_gth_addr | output | 1 | Payload word is a gather address |
| out_undef | output | 1 | Undefined opcode |
| out_pld_last | output | 1 | Final payload word |
| out_data | output | 32 | Word passed through for payload use |

## Verification
The case that needs care is back-pressure on the last payload word of a stepped or masked header. The stall must freeze the countdown and the offset stepping in the same cycle in which the word would have completed them. The bench holds `out_ready` low on such a word for several cycles. It checks that `in_ready` drops, and that the offset and last flag shown stay those of the pending word. After release, the next word must decode as a header. A reset that arrives partway through a payload is judged the same way: the next word must be taken as a header, with the class back at zero.

// File: rtl/cmdd_pkg.sv
package cmdd_pkg;

    localparam int WORD_W     = 32;
    localparam int OPC_W      = 4;
    localparam int OFF_W      = 12;
    localparam int CLS_W      = 10;
    localparam int MASK_W     = 16;
    localparam int SCMASK_W   = 6;
    localparam int CNT_W      = 16;
    localparam int GCNT_W     = 14;
    localparam int LIDX_W     = 8;
    localparam int SUB_W      = 4;
    localparam int IMM_W      = 16;
    localparam int RST_SHIFT  = 4;
    localparam int POP_W      = $clog2(MASK_W + 1);
    localparam int BIT_W      = $clog2(MASK_W);

    localparam logic [OPC_W-1:0] OPC_SETCL   = 4'h0;
    localparam logic [OPC_W-1:0] OPC_INCR    = 4'h1;
    localparam logic [OPC_W-1:0] OPC_NONINCR = 4'h2;
    localparam logic [OPC_W-1:0] OPC_MASK    = 4'h3;
    localparam logic [OPC_W-1:0] OPC_IMM     = 4'h4;
    localparam logic [OPC_W-1:0] OPC_RESTART = 4'h5;
    localparam logic [OPC_W-1:0] OPC_GATHER  = 4'h6;
    localparam logic [OPC_W-1:0] OPC_EXTEND  = 4'hE;

    localparam logic [SUB_W-1:0] SUB_ACQ = 4'h0;
    localparam logic [SUB_W-1:0] SUB_REL = 4'h1;

    typedef enum logic [1:0] {
        LOCK_NONE = 2'd0,
        LOCK_ACQ  = 2'd1,
        LOCK_REL  = 2'd2,
        LOCK_UNK  = 2'd3
    } lock_op_e;

    typedef enum logic [2:0] {
        PM_NONE   = 3'd0,
        PM_STEP   = 3'd1,
        PM_HOLD   = 3'd2,
        PM_MASKED = 3'd3,
        PM_ADDR   = 3'd4
    } pld_mode_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [OFF_W-1:0]  offset;
        logic              cls_load;
        logic [CLS_W-1:0]  cls;
        logic [MASK_W-1:0] mask;
        logic [CNT_W-1:0]  count;
        logic [IMM_W-1:0]  imm;
        logic [LIDX_W-1:0] lock_idx;
        lock_op_e          lock_op;
        logic [WORD_W-1:0] restart_addr;
        logic              g_insert;
        logic              g_type;
        logic              undef;
        logic [CNT_W-1:0]  plen;
        pld_mode_e         pmode;
    } hdr_t;

    function automatic logic [POP_W-1:0] pop_mask(input logic [MASK_W-1:0] m);
        logic [POP_W-1:0] c;
        c = '0;
        for (int i = 0; i < MASK_W; i++) begin
            c = c + POP_W'(m[i]);
        end
        return c;
    endfunction

    function automatic logic [BIT_W-1:0] lowest_set(input logic [MASK_W-1:0] m);
        logic [BIT_W-1:0] idx;
        idx = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (m[i]) idx = BIT_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/cmdd_hdr_decode.sv
module cmdd_hdr_decode
    import cmdd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);

    logic [OPC_W-1:0]  opc;
    logic [OFF_W-1:0]  off_f;
    logic [SUB_W-1:0]  sub_f;
    logic [MASK_W-1:0] scmask;
    logic [MASK_W-1:0] wmask;

    assign opc    = word[31:28];
    assign off_f  = word[27:16];
    assign sub_f  = word[27:24];
    assign scmask = MASK_W'(word[SCMASK_W-1:0]);
    assign wmask  = word[MASK_W-1:0];

    always_comb begin
        hdr        = '0;
        hdr.opcode = opc;
        hdr.pmode  = PM_NONE;
        hdr.lock_op = LOCK_NONE;
        case (opc)
            OPC_SETCL: begin
                hdr.offset   = off_f;
                hdr.cls_load = 1'b1;
                hdr.cls      = word[15:6];
                hdr.mask     = scmask;
                hdr.plen     = CNT_W'(pop_mask(scmask));
                hdr.pmode    = PM_MASKED;
            end
            OPC_INCR: begin
                hdr.offset = off_f;
                hdr.count  = word[CNT_W-1:0];
                hdr.plen   = word[CNT_W-1:0];
                hdr.pmode  = PM_STEP;
            end
            OPC_NONINCR: begin
                hdr.offset = off_f;
                hdr.count  = word[CNT_W-1:0];
                hdr.plen   = word[CNT_W-1:0];
                hdr.pmode  = PM_HOLD;
            end
            OPC_MASK: begin
                hdr.offset = off_f;
                hdr.mask   = wmask;
                hdr.plen   = CNT_W'(pop_mask(wmask));
                hdr.pmode  = PM_MASKED;
            end
            OPC_IMM: begin
                hdr.offset = off_f;
                hdr.imm    = word[IMM_W-1:0];
            end
            OPC_RESTART: begin
                hdr.restart_addr = {word[WORD_W-RST_SHIFT-1:0], {RST_SHIFT{1'b0}}};
            end
            OPC_GATHER: begin
                hdr.offset   = off_f;
                hdr.g_insert = word[15];
                hdr.g_type   = word[14];
                hdr.count    = CNT_W'(word[GCNT_W-1:0]);
                hdr.plen     = CNT_W'(1);
                hdr.pmode    = PM_ADDR;
            end
            OPC_EXTEND: begin
                hdr.lock_idx = word[LIDX_W-1:0];
                if (sub_f == SUB_ACQ)      hdr.lock_op = LOCK_ACQ;
                else if (sub_f == SUB_REL) hdr.lock_op = LOCK_REL;
                else                       hdr.lock_op = LOCK_UNK;
            end
            default: begin
                hdr.undef = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cmdd_pld_track.sv
module cmdd_pld_track
    import cmdd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_fire,
    input  logic              pld_fire,
    input  logic [OPC_W-1:0]  ld_op,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic              ld_cls_load,
    input  logic [CLS_W-1:0]  ld_cls,
    input  logic [MASK_W-1:0] ld_mask,
    input  logic [CNT_W-1:0]  ld_plen,
    input  pld_mode_e         ld_mode,
    output logic              busy,
    output logic              last,
    output logic [OPC_W-1:0]  cur_op,
    output logic [OFF_W-1:0]  cur_off,
    output pld_mode_e         cur_mode,
    output logic [CLS_W-1:0]  cls
);

    logic [CNT_W-1:0]  rem_q;
    logic [OFF_W-1:0]  base_q;
    logic [MASK_W-1:0] mask_q;
    logic [OPC_W-1:0]  op_q;
    logic [CLS_W-1:0]  cls_q;
    pld_mode_e         mode_q;

    assign busy     = (rem_q != '0);
    assign last     = (rem_q == CNT_W'(1));
    assign cur_op   = op_q;
    assign cur_mode = mode_q;
    assign cls      = cls_q;

    always_comb begin
        if (mode_q == PM_MASKED) cur_off = base_q + OFF_W'(lowest_set(mask_q));
        else                     cur_off = base_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            base_q <= '0;
            mask_q <= '0;
            op_q   <= '0;
            cls_q  <= '0;
            mode_q <= PM_NONE;
        end else if (hdr_fire) begin
            rem_q  <= ld_plen;
            base_q <= ld_off;
            mask_q <= ld_mask;
            op_q   <= ld_op;
            mode_q <= ld_mode;
            if (ld_cls_load) cls_q <= ld_cls;
        end else if (pld_fire) begin
            rem_q <= rem_q - CNT_W'(1);
            if (mode_q == PM_STEP)   base_q <= base_q + OFF_W'(1);
            if (mode_q == PM_MASKED) mask_q <= mask_q & (mask_q - MASK_W'(1));
        end
    end

    AST_PLD_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        pld_fire |=> rem_q == $past(rem_q) - CNT_W'(1));  // R3

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (pld_fire && mode_q == PM_STEP) |=> base_q == $past(base_q) + OFF_W'(1));  // R3

    AST_HOLD_FIXED: assert property (@(posedge clk) disable iff (rst)
        (pld_fire && mode_q == PM_HOLD) |=> $stable(base_q));  // R3

    AST_MASK_DROP: assert property (@(posedge clk) disable iff (rst)
        (pld_fire && mode_q == PM_MASKED) |=> $countones(mask_q) == $countones($past(mask_q)) - 1);  // R4

    AST_GATHER_ONE: assert property (@(posedge clk) disable iff (rst)
        (hdr_fire && ld_mode == PM_ADDR) |=> rem_q == CNT_W'(1));  // R7

    AST_NO_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        (hdr_fire && ld_plen == '0) |=> !busy);  // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!hdr_fire && !pld_fire) |=> $stable(rem_q) && $stable(base_q) && $stable(mask_q));  // R10

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rem_q == '0 && cls_q == '0));  // R11

endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmdd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_is_hdr,
    output logic              out_is_pld,
    output logic [3:0]        out_opcode,
    output logic [9:0]        out_class,
    output logic [11:0]       out_offset,
    output logic [15:0]       out_mask,
    output logic [15:0]       out_count,
    output logic [15:0]       out_imm,
    output logic [7:0]        out_lock_idx,
    output logic [1:0]        out_lock_op,
    output logic [31:0]       out_restart_addr,
    output logic              out_gth_insert,
    output logic              out_gth_type,
    output logic              out_gth_addr,
    output logic              out_undef,
    output logic              out_pld_last,
    output logic [31:0]       out_data
);

    hdr_t              hdr;
    logic              busy;
    logic              last;
    logic [OPC_W-1:0]  cur_op;
    logic [OFF_W-1:0]  cur_off;
    pld_mode_e         cur_mode;
    logic [CLS_W-1:0]  cls_q;
    logic              fire;
    logic              is_hdr;
    logic              is_pld;
    logic [1:0]        lock_bits;

    cmdd_hdr_decode u_dec (
        .word (in_word),
        .hdr  (hdr)
    );

    assign fire   = in_valid && out_ready;
    assign is_hdr = in_valid && !busy;
    assign is_pld = in_valid && busy;

    cmdd_pld_track u_trk (
        .clk         (clk),
        .rst         (rst),
        .hdr_fire    (fire && !busy),
        .pld_fire    (fire && busy),
        .ld_op       (hdr.opcode),
        .ld_off      (hdr.offset),
        .ld_cls_load (hdr.cls_load),
        .ld_cls      (hdr.cls),
        .ld_mask     (hdr.mask),
        .ld_plen     (hdr.plen),
        .ld_mode     (hdr.pmode),
        .busy        (busy),
        .last        (last),
        .cur_op      (cur_op),
        .cur_off     (cur_off),
        .cur_mode    (cur_mode),
        .cls         (cls_q)
    );

    assign lock_bits = hdr.lock_op;

    assign in_ready         = out_ready;
    assign out_valid        = in_valid;
    assign out_is_hdr       = is_hdr;
    assign out_is_pld       = is_pld;
    assign out_opcode       = is_pld ? cur_op : hdr.opcode;
    assign out_class        = (is_hdr && hdr.cls_load) ? hdr.cls : cls_q;
    assign out_offset       = is_pld ? cur_off : hdr.offset;
    assign out_mask         = is_hdr ? hdr.mask : '0;
    assign out_count        = is_hdr ? hdr.count : '0;
    assign out_imm          = is_hdr ? hdr.imm : '0;
    assign out_lock_idx     = is_hdr ? hdr.lock_idx : '0;
    assign out_lock_op      = is_hdr ? lock_bits : 2'b00;
    assign out_restart_addr = is_hdr ? hdr.restart_addr : '0;
    assign out_gth_insert   = is_hdr && hdr.g_insert;
    assign out_gth_type     = is_hdr && hdr.g_type;
    assign out_gth_addr     = is_pld && (cur_mode == PM_ADDR);
    assign out_undef        = is_hdr && hdr.undef;
    assign out_pld_last     = is_pld && last;
    assign out_data         = in_word;

    AST_STALL_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !out_ready) |-> !in_ready);  // R10

    AST_LAST_THEN_HDR: assert property (@(posedge clk) disable iff (rst)
        (out_pld_last && out_ready) |=> !busy);  // R12

endmodule

// File: tb/cmd_stream_decoder_tb.sv
module cmd_stream_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_ready = 1'b1;
    logic        in_ready, out_valid, out_is_hdr, out_is_pld;
    logic [3:0]  out_opcode;
    logic [9:0]  out_class;
    logic [11:0] out_offset;
    logic [15:0] out_mask, out_count, out_imm;
    logic [7:0]  out_lock_idx;
    logic [1:0]  out_lock_op;
    logic [31:0] out_restart_addr, out_data;
    logic        out_gth_insert, out_gth_type, out_gth_addr, out_undef, out_pld_last;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cmd_stream_decoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
        .out_is_hdr(out_is_hdr), .out_is_pld(out_is_pld), .out_opcode(out_opcode),
        .out_class(out_class), .out_offset(out_offset), .out_mask(out_mask),
        .out_count(out_count), .out_imm(out_imm), .out_lock_idx(out_lock_idx),
        .out_lock_op(out_lock_op), .out_restart_addr(out_restart_addr),
        .out_gth_insert(out_gth_insert), .out_gth_type(out_gth_type),
        .out_gth_addr(out_gth_addr), .out_undef(out_undef),
        .out_pld_last(out_pld_last), .out_data(out_data)
    );

    typedef struct packed {
        logic [31:0] w;
        logic        hdr;
        logic [3:0]  op;
        logic [11:0] off;
        logic        last;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{32'h1010_0003, 1'b1, 4'h1, 12'h010, 1'b0},
        '{32'hE100_0005, 1'b0, 4'h1, 12'h010, 1'b0},
        '{32'h3000_FFFF, 1'b0, 4'h1, 12'h011, 1'b0},
        '{32'h0000_0000, 1'b0, 4'h1, 12'h012, 1'b1},
        '{32'h2020_0002, 1'b1, 4'h2, 12'h020, 1'b0},
        '{32'h6000_0001, 1'b0, 4'h2, 12'h020, 1'b0},
        '{32'h1111_1111, 1'b0, 4'h2, 12'h020, 1'b1},
        '{32'h3030_0005, 1'b1, 4'h3, 12'h030, 1'b0},
        '{32'h0000_0001, 1'b0, 4'h3, 12'h030, 1'b0},
        '{32'h0000_0002, 1'b0, 4'h3, 12'h032, 1'b1},
        '{32'h0040_0E83, 1'b1, 4'h0, 12'h040, 1'b0},
        '{32'hFFFF_FFFF, 1'b0, 4'h0, 12'h040, 1'b0},
        '{32'h2222_2222, 1'b0, 4'h0, 12'h041, 1'b1},
        '{32'h6050_C005, 1'b1, 4'h6, 12'h050, 1'b0},
        '{32'h1234_5670, 1'b0, 4'h6, 12'h050, 1'b1},
        '{32'h4060_BEEF, 1'b1, 4'h4, 12'h060, 1'b0},
        '{32'h7000_0003, 1'b1, 4'h7, 12'h000, 1'b0},
        '{32'h1070_0000, 1'b1, 4'h1, 12'h070, 1'b0},
        '{32'h5ABC_DEF1, 1'b1, 4'h5, 12'h000, 1'b0},
        '{32'hE000_002A, 1'b1, 4'hE, 12'h000, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        #5;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-reqs act=timeout exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        apply(32'h1000_0000);
        chk("R11 reset hdr", 32'(out_is_hdr), 32'd1);
        chk("R11 reset class", 32'(out_class), 32'd0);

        // R1 R3 R4 R12: table walk
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].w);
            chk($sformatf("R1 tbl%0d hdr", i), 32'(out_is_hdr), 32'(TBL[i].hdr));
            chk($sformatf("R1 tbl%0d pld", i), 32'(out_is_pld), 32'(!TBL[i].hdr));
            chk($sformatf("R1 tbl%0d op", i), 32'(out_opcode), 32'(TBL[i].op));
            chk($sformatf("R3 tbl%0d off", i), 32'(out_offset), 32'(TBL[i].off));
            chk($sformatf("R12 tbl%0d last", i), 32'(out_pld_last), 32'(TBL[i].last));
        end

        // R2: class persists, fields of set-class
        apply(32'h4000_0000);
        chk("R2 class kept", 32'(out_class), 32'h3A);
        apply(32'h0040_0E83);
        chk("R2 setcl class", 32'(out_class), 32'h3A);
        chk("R2 setcl mask", 32'(out_mask), 32'h3);
        apply(32'h0); apply(32'h0);

        // R5 immediate
        apply(32'h4060_BEEF);
        chk("R5 imm", 32'(out_imm), 32'hBEEF);
        apply(32'h4061_0001);
        chk("R5 no payload", 32'(out_is_hdr), 32'd1);

        // R6 restart
        apply(32'h5ABC_DEF1);
        chk("R6 addr", out_restart_addr, 32'hABCD_EF10);

        // R7 gather
        apply(32'h6050_C005);
        chk("R7 insert", 32'(out_gth_insert), 32'd1);
        chk("R7 type", 32'(out_gth_type), 32'd1);
        chk("R7 count", 32'(out_count), 32'd5);
        apply(32'h1234_5670);
        chk("R7 addr tag", 32'(out_gth_addr), 32'd1);
        chk("R7 addr data", out_data, 32'h1234_5670);
        apply(32'h6051_3FFF);
        chk("R7 after one", 32'(out_is_hdr), 32'd1);
        chk("R7 count max", 32'(out_count), 32'h3FFF);
        chk("R7 flags clear", 32'({out_gth_insert, out_gth_type}), 32'd0);
        apply(32'h0);

        // R8 extend
        apply(32'hE000_002A);
        chk("R8 acq op", 32'(out_lock_op), 32'd1);
        chk("R8 acq idx", 32'(out_lock_idx), 32'h2A);
        apply(32'hE100_0007);
        chk("R8 rel op", 32'(out_lock_op), 32'd2);
        chk("R8 rel idx", 32'(out_lock_idx), 32'h07);
        apply(32'hE500_0001);
        chk("R8 unk op", 32'(out_lock_op), 32'd3);
        apply(32'h4000_0000);
        chk("R8 non-extend", 32'(out_lock_op), 32'd0);

        // R9 undefined
        apply(32'hF000_FFFF);
        chk("R9 undef F", 32'(out_undef), 32'd1);
        apply(32'h8000_0002);
        chk("R9 next hdr", 32'(out_is_hdr), 32'd1);
        chk("R9 undef 8", 32'(out_undef), 32'd1);
        apply(32'h1000_0000);
        chk("R9 defined", 32'(out_undef), 32'd0);

        // R4 high mask bit
        apply(32'h3300_8001);
        chk("R4 mask", 32'(out_mask), 32'h8001);
        apply(32'h0);
        chk("R4 first", 32'(out_offset), 32'h300);
        chk("R12 not last", 32'(out_pld_last), 32'd0);
        apply(32'h0);
        chk("R4 second", 32'(out_offset), 32'h30F);
        chk("R12 last", 32'(out_pld_last), 32'd1);

        // R10 back-pressure on final payload word
        apply(32'h1200_0002);
        apply(32'hAAAA_0001);
        chk("R10 pld1 off", 32'(out_offset), 32'h200);
        @(negedge clk);
        out_ready = 1'b0;
        in_word   = 32'hBBBB_0002;
        #5;
        chk("R10 in_ready low", 32'(in_ready), 32'd0);
        repeat (3) @(negedge clk);
        #5;
        chk("R10 held pld", 32'(out_is_pld), 32'd1);
        chk("R10 held off", 32'(out_offset), 32'h201);
        chk("R10 held last", 32'(out_pld_last), 32'd1);
        @(negedge clk);
        out_ready = 1'b1;
        #5;
        chk("R10 release ready", 32'(in_ready), 32'd1);
        chk("R10 release off", 32'(out_offset), 32'h201);
        apply(32'h4000_0000);
        chk("R10 then hdr", 32'(out_is_hdr), 32'd1);

        // R2 zero mask set-class
        apply(32'h0000_0100);
        chk("R2 zero mask class", 32'(out_class), 32'd4);
        apply(32'h1000_0000);
        chk("R2 zero mask hdr", 32'(out_is_hdr), 32'd1);
        chk("R2 class 4 kept", 32'(out_class), 32'd4);

        // R11 reset mid-payload
        apply(32'h1100_0005);
        apply(32'h9999_9999);
        chk("R11 pre pld", 32'(out_is_pld), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        apply(32'h2000_0001);
        chk("R11 mid hdr", 32'(out_is_hdr), 32'd1);
        chk("R11 mid class", 32'(out_class), 32'd0);

        @(negedge clk);
        in_valid = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule